// File: doc/BRIEF.md
# DMA Stream Staging FIFO with Width Conversion and Threshold

This block is the per-stream staging buffer of a DMA stream. It sits between the side that reads the source and the side that writes the destination. It holds four 32-bit words, which is 16 bytes, and counts its fill level in bytes. Each write strobe carries a byte, a half-word or a word, and so does each read strobe. The two widths are chosen independently, so narrow source items are packed into words and wide words are unpacked into narrow destination items. Bytes are stored little-endian: the oldest byte sits in the lowest lane.

A two-bit threshold select sets the fill level at which `thr_hit` rises. The levels are one, two or three quarters of the depth, or completely full. The destination side uses `thr_hit` to launch a burst of 4, 8 or 16 beats from the stored data. A write that does not fit, or a read that asks for more bytes than are held, is dropped, and a one-cycle `fifo_err` pulse reports it.

In direct mode there is no accumulation. The buffer holds at most one item, which is accepted only when the buffer is empty. A read returns that whole item at its written width and empties the buffer. While an item is held, `full` and `thr_hit` are asserted. This lets a memory source preload one item, so the item is ready as soon as the destination asks for it. Width conversion is therefore possible only in FIFO mode.

Top module: `dma_stage_fifo`

## Requirements
- R1: After reset, level is 0, empty is 1, and full, thr_hit and fifo_err are 0.
- R2: The size code is 0 for a byte, 1 for a half-word, and 2 or 3 for a word, on both the write and the read side. An accepted write raises level by that many bytes, and an accepted read lowers it by that many, one cycle after the strobe.
- R3: Writes are packed little-endian, with the first byte written stored in bits 7:0. While rd_en is high, rd_data carries the oldest bytes, oldest in bits 7:0, for the selected read size, and the unused upper lanes are 0.
- R4: A wide item that is read back in narrower pieces comes out lowest lane first: a word read as four bytes yields bits 7:0, then 15:8, then 23:16, then 31:24.
- R5: In FIFO mode, thr_hit is 1 when level is at least 4, 8, 12 or 16 bytes, for thr_sel 0, 1, 2 and 3 respectively.
- R6: In FIFO mode, full is 1 exactly when level is 16, and empty is 1 exactly when level is 0.
- R7: A write whose byte count exceeds the free space, measured before any read in the same cycle, leaves the contents unchanged. It raises fifo_err for the following cycle only.
- R8: A read whose byte count exceeds level leaves the contents unchanged and raises fifo_err for the following cycle only.
- R9: In direct mode, a write is accepted only when the buffer is empty. A read ignores rd_size, returns the whole held item at its written width, and empties the buffer. full and thr_hit are 1 while an item is held.
- R10: In direct mode, a write while an item is held, or a read while empty, changes nothing and raises fifo_err the next cycle.
- R11: In FIFO mode, a read and a write that are both accepted in the same cycle are both applied, and level changes by their difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| direct_mode | input | 1 | 1 selects single-item pass-through |
| thr_sel | input | 2 | Threshold in quarters of the depth (3 = full) |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Write item size code |
| wr_data | input | 32 | Write item, right-aligned |
| rd_en | input | 1 | Read strobe |
| rd_size | input | 2 | Read item size code (ignored in direct mode) |
| rd_data | output | 32 | Oldest bytes for the current read, right-aligned |
| level | output | 5 | Fill level in bytes |
| full | output | 1 | No room (FIFO) or item held (direct) |
| empty | output | 1 | Nothing held |
| thr_hit | output | 1 | Threshold reached / item ready |
| fifo_err | output | 1 | One-cycle pulse after a dropped access |

## Verification
`rd_data` is combinational and is due in the same cycle as `rd_en`, so the bench samples it shortly after it drives the strobe, before the clock edge. Level, `full`, `empty` and `thr_hit` follow one edge after an accepted strobe. `fifo_err` is a registered pulse that is high only in the cycle after the dropped access. The bench therefore steps its byte-queue model at each rising edge and compares every registered output just after that edge.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    // Byte count carried by a size code; code 3 behaves as a word.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmaf_store.sv
module dmaf_store #(
    parameter int DATA_W  = 32,
    parameter int DEPTH_B = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [2:0]        wr_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_go,
    input  logic [2:0]        rd_n,
    output logic [DATA_W-1:0] peek_data
);
    localparam int LANES = DATA_W / 8;
    localparam int PW    = $clog2(DEPTH_B);

    typedef struct packed {
        logic [DEPTH_B-1:0][7:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(wr_n)) begin
                    st_d.mem[st_q.wp + PW'(i)] = wr_data[8*i +: 8];
                end
            end
            st_d.wp = st_q.wp + PW'(wr_n);
        end
        if (rd_go) begin
            st_d.rp = st_q.rp + PW'(rd_n);
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            peek_data[8*i +: 8] = st_q.mem[st_q.rp + PW'(i)];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dmaf_thresh.sv
module dmaf_thresh #(
    parameter int DEPTH_B = 16,
    parameter int LW      = $clog2(DEPTH_B + 1)
) (
    input  logic [LW-1:0] level,
    input  logic [1:0]    thr_sel,
    input  logic          direct_mode,
    output logic          thr_hit,
    output logic          full,
    output logic          empty
);
    localparam int QUART = DEPTH_B / 4;

    logic [LW-1:0] limit;

    always_comb begin
        limit = LW'((int'(thr_sel) + 1) * QUART);
        empty = (level == '0);
        if (direct_mode) begin
            full    = !empty;
            thr_hit = !empty;
        end else begin
            full    = (level == LW'(DEPTH_B));
            thr_hit = (level >= limit);
        end
    end
endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo
    import dmaf_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              direct_mode,
    input  logic [1:0]                        thr_sel,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_size,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              rd_en,
    input  logic [1:0]                        rd_size,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [$clog2(WORDS*DATA_W/8+1)-1:0] level,
    output logic                              full,
    output logic                              empty,
    output logic                              thr_hit,
    output logic                              fifo_err
);
    localparam int LANES   = DATA_W / 8;
    localparam int DEPTH_B = WORDS * LANES;
    localparam int LW      = $clog2(DEPTH_B + 1);

    typedef struct packed {
        logic [LW-1:0] level;
        logic          err;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [LW-1:0] wn, rn;
    logic          wr_ok, rd_ok;
    logic [DATA_W-1:0] peek;

    always_comb begin
        wn = LW'(size_bytes(wr_size));
        rn = direct_mode ? ctl_q.level : LW'(size_bytes(rd_size));
        if (direct_mode) begin
            rd_ok = rd_en && (ctl_q.level != '0);
            wr_ok = wr_en && (ctl_q.level == '0);
        end else begin
            rd_ok = rd_en && (ctl_q.level >= rn);
            wr_ok = wr_en && ((LW'(DEPTH_B) - ctl_q.level) >= wn);
        end
        ctl_d.err   = (rd_en && !rd_ok) || (wr_en && !wr_ok);
        ctl_d.level = ctl_q.level + (wr_ok ? wn : '0) - (rd_ok ? rn : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dmaf_store #(.DATA_W(DATA_W), .DEPTH_B(DEPTH_B)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_ok),
        .wr_n     (3'(wn)),
        .wr_data  (wr_data),
        .rd_go    (rd_ok),
        .rd_n     (3'(rn)),
        .peek_data(peek)
    );

    dmaf_thresh #(.DEPTH_B(DEPTH_B), .LW(LW)) u_thr (
        .level      (ctl_q.level),
        .thr_sel    (thr_sel),
        .direct_mode(direct_mode),
        .thr_hit    (thr_hit),
        .full       (full),
        .empty      (empty)
    );

    // Present only the lanes the current read consumes.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rd_data[8*i +: 8] = (LW'(i) < rn) ? peek[8*i +: 8] : 8'h00;
        end
    end

    assign level    = ctl_q.level;
    assign fifo_err = ctl_q.err;
endmodule

// File: rtl/dmaf_chk.sv
module dmaf_chk #(
    parameter int DEPTH_B = 16,
    parameter int LW      = $clog2(DEPTH_B + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          direct_mode,
    input logic [1:0]    thr_sel,
    input logic          wr_en,
    input logic          rd_en,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          thr_hit,
    input logic          fifo_err
);
    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH_B));

    // R8
    empty_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && empty |=> fifo_err);

    // R7
    full_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && full |=> fifo_err);

    // R8
    empty_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && empty |=> $stable(level));

    // R5
    full_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !direct_mode && thr_sel == 2'b11 && thr_hit |-> full);

    // R9
    direct_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode && !empty |-> full && thr_hit);

    // R6
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind dma_stage_fifo dmaf_chk #(.DEPTH_B(DEPTH_B), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .thr_sel(thr_sel),
    .wr_en(wr_en), .rd_en(rd_en), .level(level), .full(full), .empty(empty),
    .thr_hit(thr_hit), .fifo_err(fifo_err)
);

// File: tb/dma_stage_fifo_test.sv
module dma_stage_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        direct_mode = 1'b0;
    logic [1:0]  thr_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_size = 2'd0;
    logic [31:0] rd_data;
    logic [4:0]  level;
    logic        full, empty, thr_hit, fifo_err;

    int errors = 0;
    int checks = 0;
    logic [7:0] mq[$];
    logic exp_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_stage_fifo uut (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .thr_sel(thr_sel),
        .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
        .rd_en(rd_en), .rd_size(rd_size), .rd_data(rd_data),
        .level(level), .full(full), .empty(empty), .thr_hit(thr_hit),
        .fifo_err(fifo_err)
    );

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        int lv = mq.size();
        logic ef, ff, th;
        ef = (lv == 0);
        if (direct_mode) begin
            ff = (lv != 0); th = (lv != 0);
        end else begin
            ff = (lv == DEPTH); th = (lv >= (int'(thr_sel) + 1) * 4);
        end
        chk(tag, "level", 32'(level), 32'(lv));
        chk(tag, "empty", 32'(empty), 32'(ef));
        chk(tag, "full", 32'(full), 32'(ff));
        chk(tag, "thr_hit", 32'(thr_hit), 32'(th));
        chk(tag, "fifo_err", 32'(fifo_err), 32'(exp_err));
    endtask

    task automatic step(input string tag, input logic we, input logic [1:0] ws,
                        input logic [31:0] wd, input logic re, input logic [1:0] rs);
        int wn, rn, lv;
        logic wok, rok;
        logic [31:0] expd;
        @(negedge clk);
        wr_en = we; wr_size = ws; wr_data = wd; rd_en = re; rd_size = rs;
        lv = mq.size();
        wn = nbytes(ws);
        rn = direct_mode ? lv : nbytes(rs);
        rok = re && (direct_mode ? (lv != 0) : (lv >= rn));
        wok = we && (direct_mode ? (lv == 0) : (DEPTH - lv >= wn));
        #1;
        if (rok) begin
            expd = '0;
            for (int i = 0; i < rn; i++) expd[8*i +: 8] = mq[i];
            chk(tag, "rd_data", rd_data, expd);
        end
        @(posedge clk);
        if (rok) for (int i = 0; i < rn; i++) void'(mq.pop_front());
        if (wok) for (int i = 0; i < wn; i++) mq.push_back(wd[8*i +: 8]);
        exp_err = (re && !rok) || (we && !wok);
        #1;
        check_state(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 2'd0, 32'h0, 1'b0, 2'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check_state("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R3: four bytes packed, read as one word
        step("R3", 1, 2'd0, 32'h11, 0, 0);
        step("R3", 1, 2'd0, 32'h22, 0, 0);
        step("R3", 1, 2'd0, 32'h33, 0, 0);
        step("R3", 1, 2'd0, 32'h44, 0, 0);
        step("R3", 0, 0, 0, 1, 2'd2);

        // R4: word unpacked as bytes, then as halves
        step("R4", 1, 2'd2, 32'hA1B2C3D4, 0, 0);
        for (int i = 0; i < 4; i++) step("R4", 0, 0, 0, 1, 2'd0);
        step("R4", 1, 2'd2, 32'h5566_7788, 0, 0);
        step("R4", 0, 0, 0, 1, 2'd1);
        step("R4", 0, 0, 0, 1, 2'd1);

        // R2: half-words, size code 3 as a word
        step("R2", 1, 2'd1, 32'hFFFF_BEEF, 0, 0);
        step("R2", 1, 2'd3, 32'hCAFE_F00D, 0, 0);
        step("R2", 1, 2'd1, 32'h0000_1234, 0, 0);
        step("R2", 0, 0, 0, 1, 2'd2);
        step("R2", 0, 0, 0, 1, 2'd2);

        // R5/R6: each threshold while filling and draining byte by byte
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s);
            for (int i = 0; i < 16; i++) step("R5", 1, 2'd0, 32'(i + 16*s), 0, 0);
            step("R6", 0, 0, 0, 0, 0);
            for (int i = 0; i < 16; i++) step("R5", 0, 0, 0, 1, 2'd0);
        end

        // R7: overflow when full and when space is short
        thr_sel = 2'd3;
        for (int i = 0; i < 4; i++) step("R7", 1, 2'd2, 32'h0101_0101 * (i + 1), 0, 0);
        step("R7", 1, 2'd0, 32'hEE, 0, 0);
        idle("R7");
        step("R7", 0, 0, 0, 1, 2'd1);
        step("R7", 1, 2'd2, 32'hDEAD_BEEF, 0, 0);
        step("R7", 1, 2'd2, 32'hDEAD_BEEF, 1, 2'd1);
        step("R7", 1, 2'd1, 32'h0000_ABCD, 0, 0);

        // R11: simultaneous accepted read and write
        step("R11", 1, 2'd0, 32'h5A, 1, 2'd2);
        step("R11", 1, 2'd2, 32'h0BAD_F00D, 1, 2'd2);
        for (int i = 0; i < 5; i++) step("R11", 0, 0, 0, 1, 2'd2);

        // R8: underflow
        while (mq.size() > 0) step("R8", 0, 0, 0, 1, 2'd0);
        step("R8", 0, 0, 0, 1, 2'd0);
        step("R8", 1, 2'd1, 32'h0000_7711, 0, 0);
        step("R8", 0, 0, 0, 1, 2'd2);
        idle("R8");
        step("R8", 0, 0, 0, 1, 2'd1);

        // R9/R10: direct mode
        direct_mode = 1'b1;
        step("R10", 0, 0, 0, 1, 2'd2);
        step("R9", 1, 2'd1, 32'h0000_C0DE, 0, 0);
        step("R10", 1, 2'd2, 32'h1234_5678, 0, 0);
        step("R9", 0, 0, 0, 1, 2'd0);
        step("R9", 1, 2'd2, 32'h8765_4321, 0, 0);
        step("R9", 1, 2'd0, 32'h99, 1, 2'd1);
        step("R9", 1, 2'd0, 32'h99, 1, 2'd2);
        step("R9", 0, 0, 0, 1, 2'd2);
        idle("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule